// File: doc/BRIEF.md
# Display Frame Header Decoder and Size Validator

At the start of each display frame this block reads the first word of the frame buffer's in-band header. It combines that word with the programmed panel width, panel height, load mode and subpanel window. From these it works out how the pixel fetch must walk the buffer: bits per pixel, the colour path, the byte offset where pixels begin after the palette, the line stride, the range of lines to draw, and the byte offset of the first drawn line.

It also checks that the frame fits inside the active buffer. A small slack of two bytes is allowed. A frame that does not fit raises a sync-error pulse, and the surrounding controller must then turn the panel off. A frame with an unsupported depth code, or a load mode that loads only the palette, is skipped. Every accepted frame raises a done bit for the buffer it came from. In dual-buffer mode the active buffer then alternates.

Each frame takes a short state sequence: idle, decode, check, done. The decoded parameters are registered and stay stable until the next accepted frame.

Top module: `lcd_frame_hdr`

## Requirements
- R1: After reset, `params_valid`, `sync_err`, `frame_skip`, `done_cond` and `cur_buf` are all zero, and so are every decoded parameter output.
- R2: The depth code is `hdr_word[14:12]`. Code 1 gives `bpp`=2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16.
- R3: A frame with depth code 0, or with `load_mode`=1, produces a one-cycle `frame_skip` pulse. The pulse is high in the second cycle after the `frame_start` cycle. No `params_valid`, `sync_err` or `done_cond` goes with it.
- R4: `data_off` is 0 when `load_mode`=2. Otherwise it is 512 for depth codes 3 to 7 and 32 for codes 1 and 2.
- R5: A frame is accepted only if `data_off + (width*height*bpp)/8 <= size + 2`, where size is the active buffer's size. Otherwise a one-cycle `sync_err` pulse is raised in place of `params_valid`.
- R6: `color_path` is 0 (indexed) below 16 bpp. At 16 bpp it is 2 (direct 16-bit) when `tft`=1 and 1 (passive 12-bit) when `tft`=0.
- R7: When `sub_cfg[31]`=1 and `sub_cfg[29]`=1, `line_first` is `sub_cfg[25:16]` and `line_end` is `height`. When `sub_cfg[31]`=1 and `sub_cfg[29]`=0, `line_first` is 0 and `line_end` is `sub_cfg[25:16]`. When `sub_cfg[31]`=0 the window is 0 to `height`.
- R8: `stride` is `(width*bpp)/8`, and `first_addr` is `data_off + stride*line_first`.
- R9: On acceptance, `done_cond` carries a one-cycle pulse on bit `cur_buf` (bit 0 for buffer 0, bit 1 for buffer 1). The size check uses `buf0_size` or `buf1_size` by `cur_buf`. `cur_buf` toggles after acceptance only when `dual`=1.
- R10: `params_valid` or `sync_err` is high for exactly one cycle, the third cycle after the `frame_start` cycle. At most one of the three result pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start strobe, sampled while idle |
| hdr_word | input | 16 | First header word of the active buffer |
| width | input | 11 | Panel width in pixels, 1 to 1024 |
| height | input | 11 | Panel height in lines, 1 to 1024 |
| load_mode | input | 2 | 0/3: palette and data, 1: palette only, 2: data only |
| tft | input | 1 | Active-matrix panel selects the 16-bit path |
| dual | input | 1 | Alternate between two buffers |
| sub_cfg | input | 32 | Subpanel window control |
| buf0_size | input | 32 | Byte size of buffer 0 |
| buf1_size | input | 32 | Byte size of buffer 1 |
| params_valid | output | 1 | Accepted-frame pulse |
| sync_err | output | 1 | Frame-too-large pulse, enable must be cleared |
| frame_skip | output | 1 | Unsupported or palette-only frame pulse |
| done_cond | output | 2 | Per-buffer done pulse |
| cur_buf | output | 1 | Active buffer index |
| bpp | output | 5 | Bits per pixel |
| color_path | output | 2 | Pixel conversion path |
| data_off | output | 10 | Byte offset of pixel data |
| stride | output | 16 | Bytes per line |
| line_first | output | 10 | First drawn line |
| line_end | output | 11 | One past last drawn line |
| first_addr | output | 32 | Byte offset of first drawn line |

## Verification
The assertions assume that all frame inputs are held steady from the `frame_start` cycle until a result pulse appears. They also assume that `width` and `height` stay within 1 to 1024, and that `frame_start` is only raised while the block is idle. The bench changes its inputs only between frames. It draws dimensions from a small range and waits for each result pulse before it starts the next frame. It places buffer sizes a few bytes on either side of the fit limit, so that both the accept and reject outcomes occur.

// File: rtl/lcd_hdr_pkg.sv
package lcd_hdr_pkg;

    localparam int PAL_SHORT_BYTES = 32;
    localparam int PAL_LONG_BYTES  = 512;
    localparam int SIZE_SLACK      = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_CHECK  = 2'd2,
        ST_DONE   = 2'd3
    } fsm_t;

    typedef enum logic [1:0] {
        PATH_INDEXED   = 2'd0,
        PATH_PASSIVE12 = 2'd1,
        PATH_DIRECT16  = 2'd2
    } path_t;

    typedef struct packed {
        logic       ok;
        logic [4:0] bpp;
        logic [9:0] off;
        path_t      path;
    } hdr_dec_t;

    function automatic logic [4:0] depth_bpp(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd0:    return 5'd0;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [9:0] palette_bytes(input logic [2:0] code,
                                                 input logic [1:0] mode);
        if (mode == 2'd2)
            return 10'd0;
        else if (code >= 3'd3)
            return 10'(PAL_LONG_BYTES);
        else
            return 10'(PAL_SHORT_BYTES);
    endfunction

endpackage

// File: rtl/lcd_hdr_decode.sv
module lcd_hdr_decode
    import lcd_hdr_pkg::*;
#(
    parameter int CODE_LSB = 12
) (
    input  logic [15:0] hdr_word,
    input  logic [1:0]  load_mode,
    input  logic        tft,
    output hdr_dec_t    dec
);
    logic [2:0] code;

    always_comb begin
        code     = hdr_word[CODE_LSB +: 3];
        dec.ok   = (code != 3'd0) && (load_mode != 2'd1);
        dec.bpp  = depth_bpp(code);
        dec.off  = palette_bytes(code, load_mode);
        if (dec.bpp != 5'd16)
            dec.path = PATH_INDEXED;
        else if (tft)
            dec.path = PATH_DIRECT16;
        else
            dec.path = PATH_PASSIVE12;
    end
endmodule

// File: rtl/lcd_fit_check.sv
module lcd_fit_check
    import lcd_hdr_pkg::*;
#(
    parameter int DIM_W  = 11,
    parameter int SIZE_W = 32
) (
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [4:0]        bpp,
    input  logic [9:0]        off,
    input  logic [SIZE_W-1:0] buf_size,
    output logic              fits
);
    localparam int CMP_W = SIZE_W + 1;

    logic [SIZE_W-1:0] bits_total;
    logic [CMP_W-1:0]  need;
    logic [CMP_W-1:0]  room;

    always_comb begin
        bits_total = SIZE_W'(width) * SIZE_W'(height) * SIZE_W'(bpp);
        need       = CMP_W'(bits_total >> 3) + CMP_W'(off);
        room       = CMP_W'(buf_size) + CMP_W'(SIZE_SLACK);
        fits       = (need <= room);
    end
endmodule

// File: rtl/lcd_line_window.sv
module lcd_line_window #(
    parameter int DIM_W  = 11,
    parameter int LINE_W = 10,
    parameter int EN_BIT = 31,
    parameter int MD_BIT = 29,
    parameter int LN_LSB = 16
) (
    input  logic [31:0]       sub_cfg,
    input  logic [DIM_W-1:0]  height,
    output logic [LINE_W-1:0] first,
    output logic [DIM_W-1:0]  last_excl
);
    logic [LINE_W-1:0] field;

    always_comb begin
        field     = sub_cfg[LN_LSB +: LINE_W];
        first     = '0;
        last_excl = height;
        if (sub_cfg[EN_BIT]) begin
            if (sub_cfg[MD_BIT])
                first = field;
            else
                last_excl = DIM_W'(field);
        end
    end
endmodule

// File: rtl/lcd_frame_hdr.sv
module lcd_frame_hdr
    import lcd_hdr_pkg::*;
#(
    parameter int DIM_W    = 11,
    parameter int LINE_W   = 10,
    parameter int SIZE_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic [15:0]         hdr_word,
    input  logic [DIM_W-1:0]    width,
    input  logic [DIM_W-1:0]    height,
    input  logic [1:0]          load_mode,
    input  logic                tft,
    input  logic                dual,
    input  logic [31:0]         sub_cfg,
    input  logic [SIZE_W-1:0]   buf0_size,
    input  logic [SIZE_W-1:0]   buf1_size,
    output logic                params_valid,
    output logic                sync_err,
    output logic                frame_skip,
    output logic [1:0]          done_cond,
    output logic                cur_buf,
    output logic [4:0]          bpp,
    output logic [1:0]          color_path,
    output logic [9:0]          data_off,
    output logic [STRIDE_W-1:0] stride,
    output logic [LINE_W-1:0]   line_first,
    output logic [DIM_W-1:0]    line_end,
    output logic [SIZE_W-1:0]   first_addr
);
    fsm_t state;

    logic [15:0]       hdr_q;
    logic [DIM_W-1:0]  w_q, h_q;
    logic [1:0]        mode_q;
    logic              tft_q, dual_q;
    logic [31:0]       sub_q;
    logic [SIZE_W-1:0] size_q;

    hdr_dec_t dec_now, dec_q;

    lcd_hdr_decode u_dec (
        .hdr_word  (hdr_q),
        .load_mode (mode_q),
        .tft       (tft_q),
        .dec       (dec_now)
    );

    logic fits;

    lcd_fit_check #(.DIM_W(DIM_W), .SIZE_W(SIZE_W)) u_fit (
        .width    (w_q),
        .height   (h_q),
        .bpp      (dec_q.bpp),
        .off      (dec_q.off),
        .buf_size (size_q),
        .fits     (fits)
    );

    logic [LINE_W-1:0] win_first;
    logic [DIM_W-1:0]  win_end;

    lcd_line_window #(.DIM_W(DIM_W), .LINE_W(LINE_W)) u_win (
        .sub_cfg   (sub_q),
        .height    (h_q),
        .first     (win_first),
        .last_excl (win_end)
    );

    logic [STRIDE_W-1:0] stride_c;
    logic [SIZE_W-1:0]   addr_c;

    always_comb begin
        stride_c = STRIDE_W'((STRIDE_W'(w_q) * STRIDE_W'(dec_q.bpp)) >> 3);
        addr_c   = SIZE_W'(dec_q.off) + SIZE_W'(stride_c) * SIZE_W'(win_first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            hdr_q        <= '0;
            w_q          <= '0;
            h_q          <= '0;
            mode_q       <= '0;
            tft_q        <= 1'b0;
            dual_q       <= 1'b0;
            sub_q        <= '0;
            size_q       <= '0;
            dec_q        <= '0;
            params_valid <= 1'b0;
            sync_err     <= 1'b0;
            frame_skip   <= 1'b0;
            done_cond    <= '0;
            cur_buf      <= 1'b0;
            bpp          <= '0;
            color_path   <= '0;
            data_off     <= '0;
            stride       <= '0;
            line_first   <= '0;
            line_end     <= '0;
            first_addr   <= '0;
        end else begin
            params_valid <= 1'b0;
            sync_err     <= 1'b0;
            frame_skip   <= 1'b0;
            done_cond    <= '0;
            case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        hdr_q  <= hdr_word;
                        w_q    <= width;
                        h_q    <= height;
                        mode_q <= load_mode;
                        tft_q  <= tft;
                        dual_q <= dual;
                        sub_q  <= sub_cfg;
                        size_q <= cur_buf ? buf1_size : buf0_size;
                        state  <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    dec_q <= dec_now;
                    if (dec_now.ok) begin
                        state <= ST_CHECK;
                    end else begin
                        frame_skip <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_CHECK: begin
                    state <= ST_DONE;
                    if (fits) begin
                        params_valid       <= 1'b1;
                        done_cond[cur_buf] <= 1'b1;
                        if (dual_q)
                            cur_buf <= ~cur_buf;
                        bpp        <= dec_q.bpp;
                        color_path <= dec_q.path;
                        data_off   <= dec_q.off;
                        stride     <= stride_c;
                        line_first <= win_first;
                        line_end   <= win_end;
                        first_addr <= addr_c;
                    end else begin
                        sync_err <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_hdr_sva.sv
module lcd_hdr_sva
    import lcd_hdr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input fsm_t        state,
    input logic        params_valid,
    input logic        sync_err,
    input logic        frame_skip,
    input logic [1:0]  done_cond,
    input logic        cur_buf,
    input logic [4:0]  bpp,
    input logic [9:0]  data_off,
    input logic [31:0] first_addr
);
    // R10
    excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({params_valid, sync_err, frame_skip}));

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        params_valid |=> !params_valid);

    // R10
    err_from_check_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> $past(state) == ST_CHECK);

    // R3
    skip_from_decode_chk: assert property (@(posedge clk) disable iff (rst)
        frame_skip |-> $past(state) == ST_DECODE);

    // R9
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        params_valid |-> $countones(done_cond) == 1);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !params_valid |-> done_cond == 2'b00);

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !params_valid |-> $stable(cur_buf));

    // R2
    bpp_legal_chk: assert property (@(posedge clk) disable iff (rst)
        params_valid |-> ($countones(bpp) == 1 && bpp >= 5'd2));

    // R8
    addr_floor_chk: assert property (@(posedge clk) disable iff (rst)
        params_valid |-> first_addr >= 32'(data_off));
endmodule

bind lcd_frame_hdr lcd_hdr_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .params_valid (params_valid),
    .sync_err     (sync_err),
    .frame_skip   (frame_skip),
    .done_cond    (done_cond),
    .cur_buf      (cur_buf),
    .bpp          (bpp),
    .data_off     (data_off),
    .first_addr   (first_addr)
);

// File: tb/test_lcd_frame_hdr.sv
module test_lcd_frame_hdr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [15:0] hdr_word = '0;
    logic [10:0] width = 11'd1;
    logic [10:0] height = 11'd1;
    logic [1:0]  load_mode = '0;
    logic        tft = 1'b0;
    logic        dual = 1'b0;
    logic [31:0] sub_cfg = '0;
    logic [31:0] buf0_size = '0;
    logic [31:0] buf1_size = '0;

    logic        params_valid, sync_err, frame_skip, cur_buf;
    logic [1:0]  done_cond, color_path;
    logic [4:0]  bpp;
    logic [9:0]  data_off, line_first;
    logic [15:0] stride;
    logic [10:0] line_end;
    logic [31:0] first_addr;

    lcd_frame_hdr i_lcd_frame_hdr (
        .clk(clk), .rst(rst), .frame_start(frame_start), .hdr_word(hdr_word),
        .width(width), .height(height), .load_mode(load_mode), .tft(tft),
        .dual(dual), .sub_cfg(sub_cfg), .buf0_size(buf0_size),
        .buf1_size(buf1_size), .params_valid(params_valid),
        .sync_err(sync_err), .frame_skip(frame_skip), .done_cond(done_cond),
        .cur_buf(cur_buf), .bpp(bpp), .color_path(color_path),
        .data_off(data_off), .stride(stride), .line_first(line_first),
        .line_end(line_end), .first_addr(first_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_buf = 1'b0;
    bit done_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_bpp(input logic [2:0] c);
        if (c == 3'd1) return 2;
        if (c == 3'd2) return 4;
        if (c == 3'd3) return 8;
        if (c == 3'd0) return 0;
        return 16;
    endfunction

    function automatic int exp_off(input logic [2:0] c, input logic [1:0] m);
        if (m == 2'd2) return 0;
        return (c >= 3'd3) ? 512 : 32;
    endfunction

    function automatic longint need_bytes(input logic [2:0] c, input logic [1:0] m,
                                          input int w, input int h);
        return longint'(exp_off(c, m)) + (longint'(w) * h * exp_bpp(c)) / 8;
    endfunction

    task automatic run_frame(input logic [2:0] code, input logic [1:0] mode,
                             input int w, input int h, input bit t, input bit d,
                             input logic [31:0] sub, input logic [31:0] s0,
                             input logic [31:0] s1);
        int lat;
        int b, off, st, lf, le;
        longint sz;
        bit skip_e, ok_e;
        lat = 0;
        @(negedge clk);
        hdr_word  = {1'b0, code, 12'($urandom)};
        load_mode = mode; width = 11'(w); height = 11'(h);
        tft = t; dual = d; sub_cfg = sub; buf0_size = s0; buf1_size = s1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int n = 1; n <= 6; n++) begin
            if (params_valid || sync_err || frame_skip) begin
                lat = n;
                break;
            end
            @(negedge clk);
        end
        b  = exp_bpp(code);
        off = exp_off(code, mode);
        sz = model_buf ? longint'(s1) : longint'(s0);
        skip_e = (code == 3'd0) || (mode == 2'd1);
        ok_e   = !skip_e && (need_bytes(code, mode, w, h) <= sz + 2);
        if (skip_e) begin
            // R3
            check(frame_skip && lat == 2 && done_cond == 2'b00, "R3", lat, 2);
        end else if (!ok_e) begin
            // R5 R10
            check(sync_err && !params_valid && lat == 3, "R5", {sync_err, params_valid}, 2);
            check(done_cond == 2'b00, "R9", done_cond, 0);
        end else begin
            st = (w * b) / 8;
            lf = 0; le = h;
            if (sub[31]) begin
                if (sub[29]) lf = int'(sub[25:16]);
                else         le = int'(sub[25:16]);
            end
            // R10
            check(params_valid && lat == 3, "R10", lat, 3);
            // R2
            check(int'(bpp) == b, "R2", bpp, b);
            // R4
            check(int'(data_off) == off, "R4", data_off, off);
            // R6
            check(int'(color_path) == ((b != 16) ? 0 : (t ? 2 : 1)), "R6",
                  color_path, (b != 16) ? 0 : (t ? 2 : 1));
            // R7
            check(int'(line_first) == lf && int'(line_end) == le, "R7", line_first, lf);
            // R8
            check(int'(stride) == st && longint'(first_addr) == longint'(off) + longint'(st) * lf,
                  "R8", first_addr, longint'(off) + longint'(st) * lf);
            // R9
            check(done_cond == (model_buf ? 2'b10 : 2'b01), "R9", done_cond,
                  model_buf ? 2 : 1);
            if (d) model_buf = ~model_buf;
        end
        @(negedge clk);
        // R10 R9
        check(!params_valid && !sync_err && !frame_skip, "R10",
              {params_valid, sync_err, frame_skip}, 0);
        check(cur_buf == model_buf, "R9", cur_buf, model_buf);
        @(negedge clk);
    endtask

    initial begin
        longint nd;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check(!params_valid && !sync_err && !frame_skip && done_cond == 0 && !cur_buf &&
              bpp == 0 && data_off == 0 && stride == 0 && first_addr == 0 &&
              line_end == 0 && line_first == 0 && color_path == 0, "R1", cur_buf, 0);

        // directed corners
        nd = need_bytes(3'd3, 2'd0, 16, 4);
        run_frame(3'd3, 2'd0, 16, 4, 0, 0, 32'h0, 32'(nd - 2), 32'd0);     // R5 exact slack
        run_frame(3'd3, 2'd0, 16, 4, 0, 0, 32'h0, 32'(nd - 3), 32'd0);     // R5 one short
        run_frame(3'd2, 2'd2, 20, 3, 0, 0, 32'h0, 32'd4096, 32'd0);        // R4 mode 2
        run_frame(3'd1, 2'd0, 20, 3, 0, 0, 32'h0, 32'd4096, 32'd0);        // R4 short palette
        run_frame(3'd0, 2'd0, 8, 8, 0, 0, 32'h0, 32'd4096, 32'd4096);      // R3 code 0
        run_frame(3'd5, 2'd1, 8, 8, 0, 0, 32'h0, 32'd4096, 32'd4096);      // R3 palette only
        run_frame(3'd6, 2'd0, 10, 10, 1, 0, 32'ha005_0000, 32'd4096, 32'd0); // R6 R7 start line
        run_frame(3'd4, 2'd3, 10, 10, 0, 0, 32'h8007_0000, 32'd4096, 32'd0); // R6 R7 height
        run_frame(3'd2, 2'd0, 12, 6, 0, 1, 32'h2003_0000, 32'd4096, 32'd4096); // R9 dual
        run_frame(3'd2, 2'd0, 12, 6, 0, 1, 32'h0, 32'd4096, 32'd0);        // R9 buf1 too small
        run_frame(3'd2, 2'd0, 12, 6, 0, 1, 32'h0, 32'd0, 32'd4096);        // R9 buf1 used
        run_frame(3'd7, 2'd0, 1024, 1024, 1, 0, 32'h0, 32'd2097664, 32'd2097664); // R5 large

        // random frames
        for (int i = 0; i < 150; i++) begin
            logic [2:0] c;
            logic [1:0] m;
            int w, h;
            logic [31:0] sub, s0, s1;
            c = 3'($urandom_range(7, 0));
            m = 2'($urandom_range(3, 0));
            w = $urandom_range(64, 1);
            h = $urandom_range(64, 1);
            sub = {$urandom_range(1, 0) == 1, 1'b0, 1'($urandom), 3'b000,
                   10'($urandom_range(63, 0)), 16'h0};
            nd = need_bytes(c, m, w, h);
            s0 = 32'(nd - 2 + $urandom_range(3, 0) - 2);
            s1 = 32'(nd - 2 + $urandom_range(3, 0) - 2);
            run_frame(c, m, w, h, 1'($urandom), 1'($urandom), sub, s0, s1);
        end
        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule